// File: doc/BRIEF.md
# Key-Sequenced Watchdog on a 64-bit Timer

This block turns a 64-bit up-counter into a watchdog. Software first sets the global control register to watchdog mode, with both counter halves out of reset. It then loads the 64-bit period and the starting count. Arming takes two fixed keys, written into the key field of the watchdog control register in a fixed order, each with the enable bit set. The first key moves the block to a pre-armed state and the second starts the count.

While the watchdog runs, software repeats the same two-key pair to service it, and the second key clears the counter. A key value that is neither valid key is treated as a fault and fires at once. The count reaching the period also fires. A firing raises the system reset output for a fixed number of cycles, and an expiry also sets a sticky timeout flag. After that the block stays in a terminal state until its own reset, which acts as power-on reset.

Register access is a single-cycle write port and a combinational read port. They use byte offsets that follow the timer register map.

Top module: `wdt_keyseq`

## Requirements
- R1: After reset the state reads IDLE (code 0), the system reset output and the timeout flag are low, and the counter, period and global control registers read zero.
- R2: Arming is accepted only when global control (offset 0x24) has mode field bits [3:2] = 2 and both half-release bits [1:0] = 1. Otherwise an arm key leaves the state IDLE.
- R3: In IDLE, a write to offset 0x28 with key field [31:16] = 0xA5C6 and enable bit 14 set moves the state to PRE-ARMED (code 1). The same key with bit 14 clear is ignored, and no state reaches RUNNING directly from IDLE.
- R4: In PRE-ARMED, key 0xDA7E with bit 14 set moves the state to RUNNING (code 2). The counter then advances by one per cycle from its loaded value, and it holds while the state is not running.
- R5: In RUNNING, key 0xA5C6 moves the state to SERVICE-PENDING (code 3). Key 0xDA7E from there returns the state to RUNNING and clears the 64-bit counter to zero.
- R6: In RUNNING or SERVICE-PENDING, any other key value fires in the cycle of the write. The state becomes FIRED (code 4), and the system reset output is high for exactly PULSE_LEN (16) cycles starting the next cycle.
- R7: When the running counter equals the 64-bit period {offset 0x1C, offset 0x18}, the block fires. It also sets the timeout flag, which stays set until reset. With a period of P and the counter cleared, the output rises P+1 cycles after the clearing write.
- R8: Once the state has left IDLE, writes to the counter (0x10, 0x14), period (0x18, 0x1C) and global control are ignored. A valid key written with bit 14 clear does not stop a running watchdog.
- R9: FIRED is terminal. Further key writes change nothing and produce no second reset pulse.
- R10: With a period of zero, the block fires on the first running cycle. The system reset output is high one cycle after the starting key write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-on) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Read byte offset |
| rd_data | output | 32 | Read data for rd_addr (combinational) |
| sys_rst_o | output | 1 | System reset pulse |
| timeout_o | output | 1 | Sticky counter-expiry flag |
| state_o | output | 3 | Watchdog state code |

## Verification
The key sequencer is driven with the arm pair under a wrong global mode, without the enable bit, in the right order, and with the enable bit cleared while running. These patterns separate accepted transitions from ignored ones. The servicing pair is repeated well inside the period so that any missed counter clear shows up as a premature pulse. Servicing is then withheld, and the rise time is measured against the period. A wrong key in both running states, a zero period, and writes after firing distinguish the key-fault path, the expiry path and the terminal state. A behavioural reference model is compared against state, flags and the rotating read port on every cycle.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int DATA_W  = 32;
    localparam int KEY_W   = 16;
    localparam int KEY_LSB = 16;
    localparam int EN_BIT  = 14;

    localparam logic [KEY_W-1:0] KEY_ARM = 16'hA5C6;
    localparam logic [KEY_W-1:0] KEY_RUN = 16'hDA7E;

    // byte offsets of the register map
    localparam int OFS_CNT_LO = 'h10;
    localparam int OFS_CNT_HI = 'h14;
    localparam int OFS_PRD_LO = 'h18;
    localparam int OFS_PRD_HI = 'h1C;
    localparam int OFS_GCTL   = 'h24;
    localparam int OFS_WDCTL  = 'h28;

    localparam int          GCTL_W    = 4;
    localparam logic [1:0]  MODE_WDOG = 2'd2;

    typedef enum logic [2:0] {
        WD_IDLE  = 3'd0,
        WD_PRE   = 3'd1,
        WD_ACT   = 3'd2,
        WD_SRV   = 3'd3,
        WD_FIRED = 3'd4
    } wd_state_e;

    typedef enum logic [1:0] {
        K_ARM = 2'd0,
        K_RUN = 2'd1,
        K_BAD = 2'd2
    } key_kind_e;

    typedef struct packed {
        logic      stb;
        logic      en;
        key_kind_e kind;
    } key_evt_t;

    function automatic key_kind_e classify(input logic [KEY_W-1:0] key);
        if (key == KEY_ARM)      return K_ARM;
        else if (key == KEY_RUN) return K_RUN;
        else                     return K_BAD;
    endfunction

    function automatic logic watch_mode(input logic [GCTL_W-1:0] g);
        return (g[3:2] == MODE_WDOG) && (g[1:0] == 2'b11);
    endfunction

    function automatic logic is_running(input wd_state_e s);
        return (s == WD_ACT) || (s == WD_SRV);
    endfunction

endpackage

// File: rtl/wdt_regfile.sv
module wdt_regfile
    import wdt_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic                  lock_i,
    output logic [GCTL_W-1:0]     gctl_o,
    output logic [2*DATA_W-1:0]   period_o,
    output logic                  mode_ok_o,
    output key_evt_t              key_evt_o,
    output logic [1:0]            cnt_wr_o
);

    localparam logic [ADDR_W-1:0] A_GCTL  = ADDR_W'(OFS_GCTL);
    localparam logic [ADDR_W-1:0] A_WDCTL = ADDR_W'(OFS_WDCTL);

    logic [GCTL_W-1:0]          gctl_q;
    logic [1:0][DATA_W-1:0]     period_q;

    always_ff @(posedge clk) begin
        if (rst)
            gctl_q <= '0;
        else if (wr_en && !lock_i && wr_addr == A_GCTL)
            gctl_q <= wr_data[GCTL_W-1:0];
    end

    for (genvar h = 0; h < 2; h++) begin : g_half
        localparam logic [ADDR_W-1:0] A_PRD = ADDR_W'(OFS_PRD_LO + 4*h);
        localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(OFS_CNT_LO + 4*h);

        always_ff @(posedge clk) begin
            if (rst)
                period_q[h] <= '0;
            else if (wr_en && !lock_i && wr_addr == A_PRD)
                period_q[h] <= wr_data;
        end

        assign cnt_wr_o[h] = wr_en && !lock_i && (wr_addr == A_CNT);
    end

    assign gctl_o    = gctl_q;
    assign period_o  = period_q;
    assign mode_ok_o = watch_mode(gctl_q);

    always_comb begin
        key_evt_o.stb  = wr_en && (wr_addr == A_WDCTL);
        key_evt_o.en   = wr_data[EN_BIT];
        key_evt_o.kind = classify(wr_data[KEY_LSB +: KEY_W]);
    end

    AST_PERIOD_LOCKED: assert property (@(posedge clk) disable iff (rst)
        lock_i |=> $stable(period_q)) else $error("period changed while locked"); // R8
    AST_GCTL_LOCKED: assert property (@(posedge clk) disable iff (rst)
        lock_i |=> $stable(gctl_q)) else $error("global control changed while locked"); // R8

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
    import wdt_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  run_i,
    input  logic                  clr_i,
    input  logic                  hold_i,
    input  logic [1:0]            wr_i,
    input  logic [DATA_W-1:0]     wdata_i,
    input  logic [2*DATA_W-1:0]   period_i,
    output logic [2*DATA_W-1:0]   cnt_o,
    output logic                  expire_o
);

    localparam int CNT_W = 2 * DATA_W;

    logic [CNT_W-1:0] cnt_q;

    assign expire_o = run_i && (cnt_q == period_i);
    assign cnt_o    = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (run_i) begin
            if (!hold_i)
                cnt_q <= clr_i ? '0 : cnt_q + CNT_W'(1);
        end else begin
            for (int h = 0; h < 2; h++)
                if (wr_i[h])
                    cnt_q[h*DATA_W +: DATA_W] <= wdata_i;
        end
    end

    AST_CNT_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!run_i && wr_i == 2'b00) |=> $stable(cnt_q)) else $error("counter moved while stopped"); // R4
    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !hold_i) |=> cnt_q == '0) else $error("service did not clear counter"); // R5

endmodule

// File: rtl/wdt_key_fsm.sv
module wdt_key_fsm
    import wdt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  key_evt_t  key_evt_i,
    input  logic      mode_ok_i,
    input  logic      expire_i,
    output wd_state_e state_o,
    output logic      run_o,
    output logic      clr_o,
    output logic      bite_o,
    output logic      timeout_o
);

    wd_state_e state_q, state_d;
    logic      timeout_q;
    logic      bite, clr;

    always_comb begin
        state_d = state_q;
        bite    = 1'b0;
        clr     = 1'b0;
        unique case (state_q)
            WD_IDLE:
                if (key_evt_i.stb && key_evt_i.en && key_evt_i.kind == K_ARM && mode_ok_i)
                    state_d = WD_PRE;
            WD_PRE:
                if (key_evt_i.stb && key_evt_i.en && key_evt_i.kind == K_RUN)
                    state_d = WD_ACT;
            WD_ACT, WD_SRV: begin
                if (expire_i) begin
                    bite = 1'b1;
                end else if (key_evt_i.stb) begin
                    unique case (key_evt_i.kind)
                        K_ARM: state_d = WD_SRV;
                        K_RUN: begin
                            clr     = (state_q == WD_SRV);
                            state_d = WD_ACT;
                        end
                        default: bite = 1'b1;
                    endcase
                end
            end
            WD_FIRED: state_d = WD_FIRED;
            default:  state_d = WD_IDLE;
        endcase
        if (bite)
            state_d = WD_FIRED;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= WD_IDLE;
            timeout_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            timeout_q <= timeout_q | expire_i;
        end
    end

    assign state_o   = state_q;
    assign run_o     = is_running(state_q);
    assign clr_o     = clr;
    assign bite_o    = bite;
    assign timeout_o = timeout_q;

    AST_NO_SKIP_ARM: assert property (@(posedge clk) disable iff (rst)
        state_q == WD_IDLE |=> (state_q == WD_IDLE || state_q == WD_PRE)) else $error("skipped pre-arm"); // R3
    AST_EXPIRE_FIRES: assert property (@(posedge clk) disable iff (rst)
        expire_i |=> (state_q == WD_FIRED && timeout_q)) else $error("expiry not handled"); // R7
    AST_TIMEOUT_STICKY: assert property (@(posedge clk) disable iff (rst)
        timeout_q |=> timeout_q) else $error("timeout flag dropped"); // R7
    AST_FIRED_TERMINAL: assert property (@(posedge clk) disable iff (rst)
        state_q == WD_FIRED |=> state_q == WD_FIRED) else $error("left fired state"); // R9

endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
    parameter int PULSE_LEN = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic fire_i,
    output logic pulse_o
);

    localparam int PW = $clog2(PULSE_LEN + 1);

    logic [PW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst)
            left_q <= '0;
        else if (fire_i)
            left_q <= PW'(PULSE_LEN);
        else if (left_q != '0)
            left_q <= left_q - PW'(1);
    end

    assign pulse_o = (left_q != '0);

    AST_PULSE_STARTS: assert property (@(posedge clk) disable iff (rst)
        fire_i |=> pulse_o) else $error("no pulse after fire"); // R6
    AST_SINGLE_FIRE: assert property (@(posedge clk) disable iff (rst)
        pulse_o |-> !fire_i) else $error("second fire during pulse"); // R9

endmodule

// File: rtl/wdt_keyseq.sv
module wdt_keyseq
    import wdt_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int PULSE_LEN = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data,
    output logic              sys_rst_o,
    output logic              timeout_o,
    output logic [2:0]        state_o
);

    localparam int CNT_W = 2 * DATA_W;

    wd_state_e          state;
    logic [GCTL_W-1:0]  gctl;
    logic [CNT_W-1:0]   period, cnt;
    logic               mode_ok, run, clr, bite, expire;
    key_evt_t           key_evt;
    logic [1:0]         cnt_wr;

    wdt_regfile #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .lock_i(state != WD_IDLE),
        .gctl_o(gctl), .period_o(period), .mode_ok_o(mode_ok),
        .key_evt_o(key_evt), .cnt_wr_o(cnt_wr)
    );

    wdt_key_fsm u_fsm (
        .clk(clk), .rst(rst),
        .key_evt_i(key_evt), .mode_ok_i(mode_ok), .expire_i(expire),
        .state_o(state), .run_o(run), .clr_o(clr), .bite_o(bite),
        .timeout_o(timeout_o)
    );

    wdt_counter u_cnt (
        .clk(clk), .rst(rst),
        .run_i(run), .clr_i(clr), .hold_i(bite),
        .wr_i(cnt_wr), .wdata_i(wr_data), .period_i(period),
        .cnt_o(cnt), .expire_o(expire)
    );

    wdt_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
        .clk(clk), .rst(rst), .fire_i(bite), .pulse_o(sys_rst_o)
    );

    assign state_o = state;

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            ADDR_W'(OFS_CNT_LO): rd_data = cnt[DATA_W-1:0];
            ADDR_W'(OFS_CNT_HI): rd_data = cnt[CNT_W-1:DATA_W];
            ADDR_W'(OFS_PRD_LO): rd_data = period[DATA_W-1:0];
            ADDR_W'(OFS_PRD_HI): rd_data = period[CNT_W-1:DATA_W];
            ADDR_W'(OFS_GCTL):   rd_data = {{(32-GCTL_W){1'b0}}, gctl};
            ADDR_W'(OFS_WDCTL): begin
                rd_data[EN_BIT] = (state != WD_IDLE);
                rd_data[2:0]    = state;
            end
            default: rd_data = '0;
        endcase
    end

    AST_ARM_NEEDS_MODE: assert property (@(posedge clk) disable iff (rst)
        (state == WD_IDLE && !mode_ok) |=> state == WD_IDLE) else $error("armed outside watchdog mode"); // R2
    AST_RST_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(sys_rst_o) |-> state == WD_FIRED) else $error("pulse without firing"); // R6

endmodule

// File: tb/sim_wdt_keyseq.sv
`timescale 1ns/1ps
module sim_wdt_keyseq;

    localparam int PLEN = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_addr = 8'h10;
    logic [31:0] rd_data;
    logic        sys_rst_o, timeout_o;
    logic [2:0]  state_o;

    always #2 clk = ~clk;   // 250 MHz

    wdt_keyseq u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .sys_rst_o(sys_rst_o), .timeout_o(timeout_o), .state_o(state_o)
    );

    int    total = 0;
    int    bad   = 0;
    int    rd_idx = 0;
    bit    finished = 0;
    string cur_req = "R1";

    // ---------------- behavioural reference model ----------------
    int          m_st;
    logic [63:0] m_cnt, m_prd;
    logic [3:0]  m_gctl;
    int          m_pulse;
    bit          m_to;

    always @(posedge clk) begin : model
        bit run, ex, bite, clr, wk, en;
        logic [15:0] k;
        int ns;
        if (rst) begin
            m_st = 0; m_cnt = '0; m_prd = '0; m_gctl = '0; m_pulse = 0; m_to = 0;
        end else begin
            run  = (m_st == 2 || m_st == 3);
            ex   = run && (m_cnt == m_prd);
            wk   = wr_en && wr_addr == 8'h28;
            k    = wr_data[31:16];
            en   = wr_data[14];
            ns = m_st; bite = 0; clr = 0;
            if (m_st == 0) begin
                if (wk && en && k == 16'hA5C6 && m_gctl == 4'hB) ns = 1;
            end else if (m_st == 1) begin
                if (wk && en && k == 16'hDA7E) ns = 2;
            end else if (run) begin
                if (ex) bite = 1;
                else if (wk) begin
                    if (k == 16'hA5C6) ns = 3;
                    else if (k == 16'hDA7E) begin clr = (m_st == 3); ns = 2; end
                    else bite = 1;
                end
            end
            if (bite) m_pulse = PLEN;
            else if (m_pulse > 0) m_pulse = m_pulse - 1;
            if (ex) m_to = 1;
            if (run) begin
                if (!bite) m_cnt = clr ? 64'd0 : m_cnt + 64'd1;
            end else if (m_st == 0 && wr_en) begin
                if (wr_addr == 8'h10) m_cnt[31:0]  = wr_data;
                if (wr_addr == 8'h14) m_cnt[63:32] = wr_data;
            end
            if (m_st == 0 && wr_en) begin
                if (wr_addr == 8'h18) m_prd[31:0]  = wr_data;
                if (wr_addr == 8'h1C) m_prd[63:32] = wr_data;
                if (wr_addr == 8'h24) m_gctl       = wr_data[3:0];
            end
            if (bite) ns = 4;
            m_st = ns;
        end
    end

    function automatic logic [31:0] m_read(input logic [7:0] a);
        logic [31:0] r;
        r = '0;
        case (a)
            8'h10: r = m_cnt[31:0];
            8'h14: r = m_cnt[63:32];
            8'h18: r = m_prd[31:0];
            8'h1C: r = m_prd[63:32];
            8'h24: r = {28'd0, m_gctl};
            8'h28: begin r[14] = (m_st != 0); r[2:0] = m_st[2:0]; end
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk(cur_req, "state",   64'(state_o),   64'(m_st));
            chk(cur_req, "sys_rst", 64'(sys_rst_o), 64'(m_pulse > 0));
            chk(cur_req, "timeout", 64'(timeout_o), 64'(m_to));
            chk(cur_req, "rd_data", 64'(rd_data),   64'(m_read(rd_addr)));
        end
    end

    function automatic logic [7:0] addr_of(input int i);
        case (i)
            0: return 8'h10; 1: return 8'h14; 2: return 8'h18;
            3: return 8'h1C; 4: return 8'h24; default: return 8'h28;
        endcase
    endfunction

    function automatic logic [31:0] kw(input logic [15:0] key, input bit en);
        return {key, 1'b0, en, 14'd0};
    endfunction

    task automatic tick();
        @(posedge clk); #1;
        rd_idx  = (rd_idx + 1) % 6;
        rd_addr = addr_of(rd_idx);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) tick();
        rst = 1'b0;
    endtask

    task automatic probe(input logic [7:0] a, output logic [31:0] v);
        rd_addr = a;
        @(negedge clk);
        v = rd_data;
    endtask

    logic [31:0] v;

    initial begin : main
        int waited, high;
        do_reset();

        // R1 reset state
        cur_req = "R1";
        @(negedge clk);
        chk("R1", "state", 64'(state_o), 0);
        chk("R1", "sys_rst", 64'(sys_rst_o), 0);
        chk("R1", "timeout", 64'(timeout_o), 0);
        probe(8'h18, v); chk("R1", "period lo", 64'(v), 0);
        tick();

        // R2 mode gating
        cur_req = "R2";
        wr(8'h28, kw(16'hA5C6, 1));
        @(negedge clk); chk("R2", "no mode", 64'(state_o), 0);
        tick();
        wr(8'h24, 32'h8);                       // mode 2, halves held in reset
        wr(8'h28, kw(16'hA5C6, 1));
        @(negedge clk); chk("R2", "halves held", 64'(state_o), 0);
        tick();
        wr(8'h24, 32'hB);
        wr(8'h18, 32'd40);
        wr(8'h1C, 32'd0);
        wr(8'h10, 32'd5);

        // R3 arm
        cur_req = "R3";
        wr(8'h28, kw(16'hA5C6, 0));
        @(negedge clk); chk("R3", "no enable", 64'(state_o), 0);
        tick();
        wr(8'h28, kw(16'hA5C6, 1));
        @(negedge clk); chk("R3", "pre-armed", 64'(state_o), 1);
        tick();

        // R8 locked while pre-armed
        cur_req = "R8";
        wr(8'h10, 32'd99);
        probe(8'h10, v); chk("R8", "cnt locked", 64'(v), 5);
        tick();

        // R4 start
        cur_req = "R4";
        wr(8'h28, kw(16'hDA7E, 1));
        @(negedge clk); chk("R4", "running", 64'(state_o), 2);
        tick(); tick();
        probe(8'h10, v); chk("R4", "count", 64'(v), 64'(m_cnt[31:0]));
        tick();

        // R8 disable attempt and locked period
        cur_req = "R8";
        wr(8'h28, kw(16'hDA7E, 0));
        @(negedge clk); chk("R8", "still running", 64'(state_o), 2);
        tick();
        wr(8'h1C, 32'd7);
        probe(8'h1C, v); chk("R8", "period hi locked", 64'(v), 0);
        tick();

        // R5 service several times
        cur_req = "R5";
        for (int r = 0; r < 5; r++) begin
            wr(8'h28, kw(16'hA5C6, 1));
            @(negedge clk); chk("R5", "pending", 64'(state_o), 3);
            tick();
            wr(8'h28, kw(16'hDA7E, 1));
            probe(8'h10, v); chk("R5", "cleared", 64'(v), 0);
            repeat (15) tick();
            chk("R5", "no pulse", 64'(sys_rst_o), 0);
        end

        // R7 expiry: service then wait
        cur_req = "R7";
        wr(8'h28, kw(16'hA5C6, 1));
        wr(8'h28, kw(16'hDA7E, 1));
        waited = 0;
        while (waited < 200) begin
            tick(); waited++;
            @(negedge clk);
            if (sys_rst_o) break;
        end
        chk("R7", "rise delay", 64'(waited), 41);
        chk("R7", "timeout set", 64'(timeout_o), 1);
        chk("R7", "fired", 64'(state_o), 4);
        high = 0;
        while (sys_rst_o && high < 100) begin high++; tick(); @(negedge clk); end
        chk("R6", "pulse length", 64'(high), PLEN);

        // R9 terminal
        cur_req = "R9";
        wr(8'h28, kw(16'h1234, 1));
        wr(8'h28, kw(16'hA5C6, 1));
        repeat (4) tick();
        @(negedge clk);
        chk("R9", "stays fired", 64'(state_o), 4);
        chk("R9", "no repulse", 64'(sys_rst_o), 0);
        chk("R7", "flag kept", 64'(timeout_o), 1);
        tick();

        // R6 wrong key while running
        do_reset();
        cur_req = "R6";
        wr(8'h24, 32'hB);
        wr(8'h18, 32'd1000);
        wr(8'h28, kw(16'hA5C6, 1));
        wr(8'h28, kw(16'hDA7E, 1));
        repeat (3) tick();
        wr(8'h28, kw(16'h0000, 1));
        @(negedge clk);
        chk("R6", "key fault pulse", 64'(sys_rst_o), 1);
        chk("R6", "key fault state", 64'(state_o), 4);
        chk("R6", "no timeout flag", 64'(timeout_o), 0);
        repeat (20) tick();

        // R6 wrong key while service pending
        do_reset();
        wr(8'h24, 32'hB);
        wr(8'h18, 32'd1000);
        wr(8'h28, kw(16'hA5C6, 1));
        wr(8'h28, kw(16'hDA7E, 1));
        wr(8'h28, kw(16'hA5C6, 1));
        wr(8'h28, kw(16'hBEEF, 0));
        @(negedge clk);
        chk("R6", "pending fault", 64'(sys_rst_o), 1);
        repeat (20) tick();

        // R10 zero period
        do_reset();
        cur_req = "R10";
        wr(8'h24, 32'hB);
        wr(8'h28, kw(16'hA5C6, 1));
        wr(8'h28, kw(16'hDA7E, 1));
        @(negedge clk);
        chk("R10", "before expiry", 64'(sys_rst_o), 0);
        tick();
        @(negedge clk);
        chk("R10", "immediate expiry", 64'(sys_rst_o), 1);
        chk("R10", "timeout", 64'(timeout_o), 1);
        repeat (20) tick();

        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : watchdog
        #(4 * 200000);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog run did not complete");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule